// File: doc/BRIEF.md
# Switchable DC-Removal High-Pass Filter

This block takes signed PCM samples that arrive at the output sample rate, with one valid strobe shared by all channels, and removes any DC offset in each channel with a first-order recursive high-pass section. The coefficient is one minus a power of two, so the recursion needs only shifts and adds. The corner frequency sits far below the audio band: the pass-band gain is unity and the droop is negligible, while a constant input decays to zero.

A single enable bit, normally written by a host processor, switches the filter in or out while the block runs. With the filter out, samples pass through unchanged with the same one-cycle latency. Each channel's recursion state is held at zero, so the next time the filter is switched in it starts clean. Every channel keeps its own state. The internal accumulator carries K fractional bits and a few guard bits. The output saturates to the sample range instead of wrapping.

Top module: `dchp_filter`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid` and every output sample become 0.
- R2: `out_valid` equals `in_valid` from the previous clock edge (one-cycle latency in both modes).
- R3: With `filt_en` high and `in_valid` high, each channel computes A' = ((x - xp) << K) + A - (A >>> K), where A is its stored accumulator, xp is its previous input and `>>>` is an arithmetic (floor) shift. Its output is A' >>> K, and A' and x become the new A and xp.
- R4: The output of R3 is clamped to [-2^(DATA_W-1), 2^(DATA_W-1)-1]. It does not wrap.
- R5: With `filt_en` low and `in_valid` high, each output sample equals its input sample exactly, one cycle later.
- R6: At every clock edge where `filt_en` is low, each channel's accumulator and previous input are set to zero. The first filtered sample after re-enabling therefore equals the input sample, subject to R4.
- R7: Channels are independent. Channel c occupies bits [c*DATA_W +: DATA_W] of `in_data` and `out_data`.
- R8: Without `in_valid`, the outputs and, while enabled, the filter state do not change.
- R9: A constant input with the filter enabled decays to an output of exactly 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_en | input | 1 | 1 = high-pass active, 0 = bypass with state cleared |
| in_valid | input | 1 | Input sample strobe, common to all channels |
| in_data | input | NUM_CH*DATA_W | Packed signed input samples |
| out_valid | output | 1 | Output sample strobe |
| out_data | output | NUM_CH*DATA_W | Packed signed output samples |

## Verification
The assertions check the following on every cycle: the one-cycle strobe latency, the exact pass-through in bypass, the clearing of state while disabled, and outputs that hold between strobes. The bit-exact recursion, saturation at both rails, the clean restart after re-enabling, channel independence and the decay of DC to zero depend on sample history. Only the bench's sweeps can show them, by comparing every output sample against an arithmetic model.

// File: rtl/dchp_pkg.sv
package dchp_pkg;
    localparam int DEF_DATA_W = 16;
    localparam int DEF_K      = 10;
    localparam int DEF_NUM_CH = 2;
    localparam int GUARD_W    = 3;

    typedef enum logic {
        MODE_BYPASS = 1'b0,
        MODE_FILTER = 1'b1
    } dchp_mode_e;

    function automatic int acc_width(input int dw, input int k);
        return dw + k + GUARD_W;
    endfunction
endpackage

// File: rtl/dchp_sat.sv
module dchp_sat #(
    parameter int IN_W  = 29,
    parameter int OUT_W = 16
) (
    input  logic signed [IN_W-1:0]  val_i,
    output logic signed [OUT_W-1:0] val_o
);
    localparam logic signed [IN_W-1:0] MAXV =
        $signed({{(IN_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}});
    localparam logic signed [IN_W-1:0] MINV =
        $signed({{(IN_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}});

    always_comb begin
        if (val_i > MAXV)      val_o = MAXV[OUT_W-1:0];
        else if (val_i < MINV) val_o = MINV[OUT_W-1:0];
        else                   val_o = val_i[OUT_W-1:0];
    end
endmodule

// File: rtl/dchp_chan.sv
module dchp_chan
    import dchp_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int K      = DEF_K
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic                     vld,
    input  logic signed [DATA_W-1:0] x_i,
    output logic signed [DATA_W-1:0] y_o
);
    localparam int AW = acc_width(DATA_W, K);

    dchp_mode_e                md;
    logic signed [DATA_W-1:0]  x_prev;
    logic signed [AW-1:0]      acc, acc_nxt, y_full;
    logic signed [DATA_W:0]    diff;
    logic signed [AW-1:0]      diff_ext;
    logic signed [DATA_W-1:0]  y_sat;

    assign md       = en ? MODE_FILTER : MODE_BYPASS;
    assign diff     = {x_i[DATA_W-1], x_i} - {x_prev[DATA_W-1], x_prev};
    assign diff_ext = $signed({{(AW-DATA_W-1){diff[DATA_W]}}, diff});
    assign acc_nxt  = (diff_ext <<< K) + acc - (acc >>> K);
    assign y_full   = acc_nxt >>> K;

    dchp_sat #(.IN_W(AW), .OUT_W(DATA_W)) u_sat (
        .val_i (y_full),
        .val_o (y_sat)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            x_prev <= '0;
            acc    <= '0;
            y_o    <= '0;
        end else if (md == MODE_BYPASS) begin
            x_prev <= '0;
            acc    <= '0;
            if (vld) y_o <= x_i;
        end else if (vld) begin
            x_prev <= x_i;
            acc    <= acc_nxt;
            y_o    <= y_sat;
        end
    end

    // R6: disabled channel holds zero state on the next cycle
    p_state_clear_r6: assert property (@(posedge clk) disable iff (rst)
        !en |=> (acc == '0 && x_prev == '0));

    // R8: no strobe, no change of output or enabled state
    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (!vld && en) |=> ($stable(y_o) && $stable(acc) && $stable(x_prev)));
endmodule

// File: rtl/dchp_filter.sv
module dchp_filter
    import dchp_pkg::*;
#(
    parameter int DATA_W = DEF_DATA_W,
    parameter int K      = DEF_K,
    parameter int NUM_CH = DEF_NUM_CH
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     filt_en,
    input  logic                     in_valid,
    input  logic [NUM_CH*DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic [NUM_CH*DATA_W-1:0] out_data
);
    localparam int BUS_W = NUM_CH * DATA_W;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic signed [DATA_W-1:0] y_ch;
        dchp_chan #(.DATA_W(DATA_W), .K(K)) u_chan (
            .clk (clk),
            .rst (rst),
            .en  (filt_en),
            .vld (in_valid),
            .x_i ($signed(in_data[c*DATA_W +: DATA_W])),
            .y_o (y_ch)
        );
        assign out_data[c*DATA_W +: DATA_W] = y_ch;
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= in_valid;
    end

    // R2: strobe follows input strobe by one cycle
    p_latency_r2: assert property (@(posedge clk)
        out_valid == $past(in_valid && !rst));

    // R5: bypass delivers the input exactly
    p_bypass_r5: assert property (@(posedge clk) disable iff (rst)
        $past(in_valid && !filt_en && !rst) |-> (out_data == $past(in_data)));

    // R1: reset empties the output
    p_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_data == '0));

    logic [BUS_W-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: tb/dchp_filter_tb.sv
module dchp_filter_tb;
    localparam int DW = 8;
    localparam int KK = 4;
    localparam int NC = 2;

    logic clk = 1'b0;
    logic rst, filt_en, in_valid;
    logic [NC*DW-1:0] in_data, out_data;
    logic out_valid;

    int n_chk = 0, n_fail = 0;
    longint m_xp [NC];
    longint m_acc[NC];
    bit done = 0;

    always #2.5 clk = ~clk;

    dchp_filter #(.DATA_W(DW), .K(KK), .NUM_CH(NC)) u_dut (
        .clk(clk), .rst(rst), .filt_en(filt_en), .in_valid(in_valid),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint model(input int c, input bit en, input longint x);
        longint a, y;
        if (!en) begin
            m_xp[c] = 0; m_acc[c] = 0;
            return x;
        end
        a = ((x - m_xp[c]) <<< KK) + m_acc[c] - (m_acc[c] >>> KK);
        m_xp[c] = x; m_acc[c] = a;
        y = a >>> KK;
        if (y > 127) y = 127;
        if (y < -128) y = -128;
        return y;
    endfunction

    function automatic longint outs(input int c);
        logic signed [DW-1:0] v;
        v = out_data[c*DW +: DW];
        return longint'(v);
    endfunction

    // drive one strobed sample on both channels; caller sits at a negedge
    task automatic send(input bit en, input int x0, input int x1, input string req);
        longint e0, e1;
        filt_en  = en;
        in_valid = 1'b1;
        in_data  = {DW'(x1), DW'(x0)};
        e0 = model(0, en, longint'(x0));
        e1 = model(1, en, longint'(x1));
        @(negedge clk);
        check("R2 out_valid", out_valid, 1);
        check({req, " ch0"}, outs(0), e0);
        check({req, " ch1"}, outs(1), e1);
        in_valid = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < 200000; i++) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        longint held;
        rst = 1'b1; filt_en = 1'b0; in_valid = 1'b0; in_data = '0;
        for (int c = 0; c < NC; c++) begin m_xp[c] = 0; m_acc[c] = 0; end
        repeat (3) @(negedge clk);
        check("R1 out_valid", out_valid, 0);
        check("R1 out_data", longint'(out_data), 0);
        rst = 1'b0;
        @(negedge clk);

        // R5 bypass sweep over every code, both channels
        for (int v = -128; v < 128; v++) send(1'b0, v, -1 - v, "R5 bypass");

        // R6 first sample after enable equals the input
        send(1'b1, 57, -90, "R6 restart");

        // R3 full ramp sweep through the recursion
        for (int v = -128; v < 128; v++) send(1'b1, v, (v * 37) % 128, "R3 ramp");

        // R4 alternating rails drive both clamps
        for (int i = 0; i < 40; i++)
            send(1'b1, (i % 2) ? 127 : -128, (i % 2) ? -128 : 127, "R4 rails");

        // R8 idle cycles keep outputs
        held = longint'(out_data);
        repeat (3) begin
            @(negedge clk);
            check("R8 valid low", out_valid, 0);
            check("R8 hold", longint'(out_data), held);
        end
        send(1'b1, 3, 3, "R8 state kept");

        // R7 independent channels: ch1 constant zero input
        send(1'b0, 0, 0, "R6 clear");
        for (int v = 0; v < 64; v++) send(1'b1, (v * 13) % 200 - 100, 0, "R7 indep");

        // R9 DC decays to zero
        send(1'b0, 0, 0, "R6 clear");
        for (int i = 0; i < 300; i++) send(1'b1, 100, -77, "R9 dc");
        check("R9 ch0 zero", outs(0), 0);
        check("R9 ch1 zero", outs(1), 0);

        // R6 mid-stream disable then enable restarts clean
        send(1'b0, 20, 30, "R5 bypass");
        send(1'b1, -128, 127, "R6 restart");

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule